// File: doc/BRIEF.md
# NAND Program-Path Rule Checker

This block stands in for the device side of a NAND flash command interface so that a flash controller can be checked against the rules for programming pages. It watches single-cycle command, address and data strobes on an 8-bit bus. It keeps a small page buffer for the bytes being loaded and holds the busy line low for a fixed number of clocks after a program or erase confirm. It answers status reads with the ready state and the result of the last program.

Two programming rules are enforced for each block. Pages must be programmed in strictly ascending order, although the page programmed most recently may be programmed again as a partial program. A page may take only a limited number of program operations between erases. A broken rule makes the program fail in the status byte. It also raises a sticky violation flag with a code that says which rule was broken. A command other than status or reset that arrives while busy is also recorded as a violation. The array contents are not modelled. Erase only clears the order and count state of one block.

Top module: `nand_prog_checker`

## Requirements
- R1: After reset `ready` is 1, `viol_flag` is 0, `viol_code` is 0, the page buffer holds 0xFF in every byte, and `io_dout` shows buffer byte 0, which is 0xFF.
- R2: Command 0x80 presets the buffer to 0xFF and is followed by five address cycles: column, a second column byte that is ignored, and three row bytes. In the first row byte, bits [5:0] are the page and bits [7:6] are the block. The other row bytes are accepted and ignored. Data cycles then write consecutive buffer columns. Command 0x85 followed by two address cycles (column, ignored byte) moves the column during a load. Outside status mode each read returns the buffer byte at the column and advances the column.
- R3: Confirm 0x10 after a load, or 0xD0 after an erase setup, drives `ready` low for exactly BUSY_CYC clock cycles.
- R4: After 0x70, every read returns the status byte: bit 6 = `ready`, bit 0 = fail result of the last program, all other bits 0. This holds until another accepted command other than 0x70 is written.
- R5: A program to a page that is neither the next page of its block nor a repeat of the page last programmed in that block fails. Status bit 0 becomes 1 and violation code 1 (order) is recorded.
- R6: A page accepts at most MAX_PART (8) program operations between erases. The next one fails with status bit 0 = 1 and violation code 2 (limit).
- R7: While busy, only 0x70 and 0xFF are accepted. Any other command is ignored and records violation code 3 (busy command).
- R8: Command 0xFF, accepted at any time, ends the busy period so that `ready` is 1 on the next cycle, returns the command sequence to idle and leaves status mode.
- R9: Command 0x60 followed by three row address cycles and then 0xD0 erases the addressed block. Page order in that block restarts at page 0, its program counts clear, and status bit 0 is cleared.
- R10: `viol_flag`, once set, stays set, and `viol_code` keeps the first violation until reset.
- R11: Once the last page (63) of a block has been programmed, only repeat programs of page 63 pass. Every other page fails with code 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wr | input | 1 | Command cycle strobe; `io_din` holds the command |
| addr_wr | input | 1 | Address cycle strobe |
| data_wr | input | 1 | Data-in cycle strobe |
| data_rd | input | 1 | Data-out cycle strobe; advances the column outside status mode |
| io_din | input | 8 | Bus byte written by the controller |
| io_dout | output | 8 | Bus byte returned for reads (status or buffer byte) |
| ready | output | 1 | High when not busy (inverse of busy line) |
| viol_flag | output | 1 | Sticky rule violation flag |
| viol_code | output | 2 | First violation: 1 order, 2 limit, 3 command while busy |

## Verification
On every cycle, the embedded assertions check the following. Status bit 6 tracks `ready`. The command sequence sits idle while busy. A confirm always produces a busy period, and a reset command always ends it. The violation record never changes once set. The per-block next-page pointer and page count stay within their bounds. Only the bench scenarios can show the order, limit and last-page rules deciding pass or fail on real address sequences, the buffer readback after a column move, the exact busy length, and the restart of page order after an erase.

// File: rtl/nand_chk_pkg.sv
// Package: command opcodes, violation codes and sequence states shared by
// the program-path rule checker. Assumes an 8-bit command bus.
package nand_chk_pkg;
    localparam logic [7:0] OP_LOAD     = 8'h80;
    localparam logic [7:0] OP_MOVE     = 8'h85;
    localparam logic [7:0] OP_CONFIRM  = 8'h10;
    localparam logic [7:0] OP_STATUS   = 8'h70;
    localparam logic [7:0] OP_RESET    = 8'hFF;
    localparam logic [7:0] OP_ERASE    = 8'h60;
    localparam logic [7:0] OP_ERASE_GO = 8'hD0;

    localparam logic [1:0] VC_NONE  = 2'd0;
    localparam logic [1:0] VC_ORDER = 2'd1;
    localparam logic [1:0] VC_LIMIT = 2'd2;
    localparam logic [1:0] VC_BUSY  = 2'd3;

    typedef enum logic [2:0] {
        ST_IDLE, ST_PADDR, ST_PDATA, ST_RADDR, ST_EADDR, ST_EWAIT
    } seq_state_t;
endpackage

// File: rtl/nand_busy_timer.sv
// Busy timer: holds ready low for BUSY_CYC cycles after start; abort ends it
// at once. Assumes BUSY_CYC >= 1 and that start only arrives while ready.
module nand_busy_timer #(
    parameter int BUSY_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic abort,
    output logic ready
);
    localparam int CW = $clog2(BUSY_CYC + 1);

    logic [CW-1:0] remain;

    // Load, abort or count down the remaining busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || abort)       remain <= '0;
        else if (start)            remain <= CW'(BUSY_CYC);
        else if (remain != '0)     remain <= remain - 1'b1;
    end

    assign ready = (remain == '0);

    a_r3_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        start && !abort |=> !ready);
    a_r8_abort_frees: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> ready);
endmodule

// File: rtl/nand_page_buf.sv
// Page buffer: BYTES bytes, preset to 0xFF on reset or fill, one write port
// and one combinational read port. Assumes fill and write never coincide.
module nand_page_buf #(
    parameter int BYTES = 16,
    localparam int AW   = $clog2(BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fill,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    logic [7:0] mem [BYTES];

    for (genvar i = 0; i < BYTES; i++) begin : g_byte
        // Preset or write one buffer byte.
        always_ff @(posedge clk) begin
            if (!rst_n || fill)                       mem[i] <= 8'hFF;
            else if (wr && addr == AW'(i))            mem[i] <= wdata;
        end
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/nand_order_tracker.sv
// Order tracker: per block, the next page allowed and the program count of
// the page programmed last. Judges a candidate (block, page) and updates on
// commit; erase clears one block. Assumes PAGES and BLOCKS are powers of two.
module nand_order_tracker #(
    parameter int PAGES    = 64,
    parameter int BLOCKS   = 4,
    parameter int MAX_PART = 8,
    localparam int PG_W    = $clog2(PAGES),
    localparam int BK_W    = $clog2(BLOCKS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [BK_W-1:0] blk,
    input  logic [PG_W-1:0] page,
    input  logic            commit,
    input  logic            erase,
    output logic            ok,
    output logic [1:0]      code
);
    import nand_chk_pkg::*;
    localparam int NX_W = PG_W + 1;
    localparam int CT_W = $clog2(MAX_PART + 1);

    logic [NX_W-1:0] nxt [BLOCKS];
    logic [CT_W-1:0] cnt [BLOCKS];
    logic            is_next, is_repeat;

    // Classify the candidate page against the block's order state.
    always_comb begin
        is_next   = ({1'b0, page} == nxt[blk]);
        is_repeat = (nxt[blk] != '0) && ({1'b0, page} == nxt[blk] - 1'b1);
        ok        = is_next || (is_repeat && cnt[blk] < CT_W'(MAX_PART));
        code      = ok ? VC_NONE : (is_repeat ? VC_LIMIT : VC_ORDER);
    end

    for (genvar b = 0; b < BLOCKS; b++) begin : g_blk
        // Advance or clear this block's order pointer and page count.
        always_ff @(posedge clk) begin
            if (!rst_n || (erase && blk == BK_W'(b))) begin
                nxt[b] <= '0;
                cnt[b] <= '0;
            end else if (commit && ok && blk == BK_W'(b)) begin
                if (is_next) begin
                    nxt[b] <= nxt[b] + 1'b1;
                    cnt[b] <= CT_W'(1);
                end else begin
                    cnt[b] <= cnt[b] + 1'b1;
                end
            end
        end

        a_r11_next_bounded: assert property (@(posedge clk) disable iff (!rst_n)
            nxt[b] <= NX_W'(PAGES));
        a_r6_count_capped: assert property (@(posedge clk) disable iff (!rst_n)
            cnt[b] <= CT_W'(MAX_PART));
    end
endmodule

// File: rtl/nand_prog_checker.sv
// Program-path rule checker: decodes command/address/data strobes, loads a
// page buffer, times the busy period, answers status reads and records the
// first rule violation. Assumes at most one strobe per cycle and
// PG_W + BK_W <= 8 (page and block fit in the first row byte).
module nand_prog_checker
    import nand_chk_pkg::*;
#(
    parameter int BUSY_CYC  = 16,
    parameter int PAGES     = 64,
    parameter int BLOCKS    = 4,
    parameter int MAX_PART  = 8,
    parameter int BUF_BYTES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_wr,
    input  logic       addr_wr,
    input  logic       data_wr,
    input  logic       data_rd,
    input  logic [7:0] io_din,
    output logic [7:0] io_dout,
    output logic       ready,
    output logic       viol_flag,
    output logic [1:0] viol_code
);
    localparam int PG_W  = $clog2(PAGES);
    localparam int BK_W  = $clog2(BLOCKS);
    localparam int COL_W = $clog2(BUF_BYTES);
    localparam int ROW_W = PG_W + BK_W;

    seq_state_t       state;
    logic [2:0]       idx;
    logic [COL_W-1:0] col;
    logic [ROW_W-1:0] row;
    logic             rd_status, fail;
    logic             confirm, erase_go, abort, start, rule_ok, busy_bad;
    logic             fill, buf_wr, col_step;
    logic [1:0]       rule_code, new_viol;
    logic [7:0]       buf_rd, status_byte;

    // Decode the strobes of this cycle into control events.
    always_comb begin
        abort    = cmd_wr && io_din == OP_RESET;
        confirm  = cmd_wr && ready && io_din == OP_CONFIRM && state == ST_PDATA;
        erase_go = cmd_wr && ready && io_din == OP_ERASE_GO && state == ST_EWAIT;
        start    = confirm || erase_go;
        busy_bad = cmd_wr && !ready && io_din != OP_STATUS && io_din != OP_RESET;
        fill     = cmd_wr && ready && io_din == OP_LOAD;
        buf_wr   = data_wr && ready && state == ST_PDATA;
        col_step = buf_wr || (data_rd && !rd_status);
        new_viol = busy_bad ? VC_BUSY : ((confirm && !rule_ok) ? rule_code : VC_NONE);
    end

    nand_busy_timer #(.BUSY_CYC(BUSY_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .ready(ready)
    );

    nand_page_buf #(.BYTES(BUF_BYTES)) u_buf (
        .clk(clk), .rst_n(rst_n), .fill(fill), .wr(buf_wr),
        .addr(col), .wdata(io_din), .rdata(buf_rd)
    );

    nand_order_tracker #(.PAGES(PAGES), .BLOCKS(BLOCKS), .MAX_PART(MAX_PART)) u_order (
        .clk(clk), .rst_n(rst_n),
        .blk(row[PG_W +: BK_W]), .page(row[PG_W-1:0]),
        .commit(confirm), .erase(erase_go),
        .ok(rule_ok), .code(rule_code)
    );

    // Command sequence, column pointer, row latch, read mode and fail bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            idx       <= '0;
            col       <= '0;
            row       <= '0;
            rd_status <= 1'b0;
            fail      <= 1'b0;
        end else if (cmd_wr) begin
            if (io_din == OP_RESET) begin
                state     <= ST_IDLE;
                idx       <= '0;
                rd_status <= 1'b0;
            end else if (io_din == OP_STATUS) begin
                rd_status <= 1'b1;
            end else if (ready) begin
                case (io_din)
                    OP_LOAD: begin
                        state <= ST_PADDR; idx <= '0; rd_status <= 1'b0;
                    end
                    OP_MOVE: if (state == ST_PDATA) begin
                        state <= ST_RADDR; idx <= '0; rd_status <= 1'b0;
                    end
                    OP_CONFIRM: if (state == ST_PDATA) begin
                        state <= ST_IDLE; fail <= !rule_ok; rd_status <= 1'b0;
                    end
                    OP_ERASE: begin
                        state <= ST_EADDR; idx <= '0; rd_status <= 1'b0;
                    end
                    OP_ERASE_GO: if (state == ST_EWAIT) begin
                        state <= ST_IDLE; fail <= 1'b0; rd_status <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end else if (addr_wr && ready) begin
            case (state)
                ST_PADDR: begin
                    if (idx == 3'd0) col <= io_din[COL_W-1:0];
                    if (idx == 3'd2) row <= io_din[ROW_W-1:0];
                    if (idx == 3'd4) state <= ST_PDATA;
                    idx <= idx + 1'b1;
                end
                ST_RADDR: begin
                    if (idx == 3'd0) col <= io_din[COL_W-1:0];
                    if (idx == 3'd1) state <= ST_PDATA;
                    idx <= idx + 1'b1;
                end
                ST_EADDR: begin
                    if (idx == 3'd0) row <= io_din[ROW_W-1:0];
                    if (idx == 3'd2) state <= ST_EWAIT;
                    idx <= idx + 1'b1;
                end
                default: ;
            endcase
        end else if (col_step) begin
            col <= col + 1'b1;
        end
    end

    // Record the first violation and hold it until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol_flag <= 1'b0;
            viol_code <= VC_NONE;
        end else if (!viol_flag && new_viol != VC_NONE) begin
            viol_flag <= 1'b1;
            viol_code <= new_viol;
        end
    end

    assign status_byte = {1'b0, ready, 5'b0, fail};
    assign io_dout     = rd_status ? status_byte : buf_rd;

    a_r4_status_mirrors_ready: assert property (@(posedge clk) disable iff (!rst_n)
        rd_status |-> io_dout[6] == ready);
    a_r10_violation_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        viol_flag |=> viol_flag && $stable(viol_code));
    a_r7_idle_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> state == ST_IDLE);
    a_r5_reject_sets_fail: assert property (@(posedge clk) disable iff (!rst_n)
        confirm && !rule_ok |=> fail);
endmodule

// File: tb/tb_nand_prog_checker.sv
module tb_nand_prog_checker;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_wr = 1'b0, addr_wr = 1'b0, data_wr = 1'b0, data_rd = 1'b0;
    logic [7:0] io_din = 8'h00;
    logic [7:0] io_dout;
    logic       ready, viol_flag;
    logic [1:0] viol_code;

    int nvec = 0;
    int nerr = 0;

    always #5 clk = ~clk;

    nand_prog_checker dut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .addr_wr(addr_wr),
        .data_wr(data_wr), .data_rd(data_rd), .io_din(io_din),
        .io_dout(io_dout), .ready(ready), .viol_flag(viol_flag),
        .viol_code(viol_code)
    );

    // kinds: 1 command, 2 address, 3 data in, 4 read and compare, 5 wait n cycles
    localparam int NV = 53;
    localparam logic [19:0] VEC [NV] = '{
        20'h1_80_00, 20'h2_00_00, 20'h2_00_00, 20'h2_00_00, 20'h2_00_00,
        20'h2_00_00, 20'h3_A5_00, 20'h3_3C_00,
        20'h1_85_00, 20'h2_00_00, 20'h2_00_00, 20'h4_00_A5, 20'h4_00_3C,
        20'h4_00_FF,
        20'h1_10_00, 20'h1_70_00, 20'h4_00_00, 20'h5_14_00, 20'h4_00_40,
        20'h4_00_40,
        20'h1_80_00, 20'h2_00_00, 20'h2_00_00, 20'h2_02_00, 20'h2_00_00,
        20'h2_00_00, 20'h3_11_00, 20'h1_10_00, 20'h1_70_00, 20'h5_14_00,
        20'h4_00_41,
        20'h1_80_00, 20'h2_00_00, 20'h2_00_00, 20'h2_01_00, 20'h2_00_00,
        20'h2_00_00, 20'h3_22_00, 20'h1_10_00, 20'h1_70_00, 20'h5_14_00,
        20'h4_00_40,
        20'h1_80_00, 20'h2_00_00, 20'h2_00_00, 20'h2_01_00, 20'h2_00_00,
        20'h2_00_00, 20'h3_44_00, 20'h1_10_00, 20'h1_70_00, 20'h5_14_00,
        20'h4_00_40
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic op(input logic [3:0] k, input logic [7:0] b);
        @(negedge clk);
        io_din = b;
        cmd_wr  = (k == 4'h1);
        addr_wr = (k == 4'h2);
        data_wr = (k == 4'h3);
        @(posedge clk);
        #1;
        cmd_wr = 1'b0; addr_wr = 1'b0; data_wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] exp);
        @(negedge clk);
        data_rd = 1'b1;
        #1 check(tag, io_dout, exp);
        @(posedge clk);
        #1 data_rd = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic prog(input logic [7:0] row0, input logic [7:0] d);
        op(4'h1, 8'h80);
        op(4'h2, 8'h00); op(4'h2, 8'h00); op(4'h2, row0);
        op(4'h2, 8'h00); op(4'h2, 8'h00);
        op(4'h3, d);
        op(4'h1, 8'h10);
    endtask

    task automatic prog_status(input string tag, input logic [7:0] row0, input logic [7:0] exp);
        prog(row0, 8'h5A);
        op(4'h1, 8'h70);
        repeat (20) @(posedge clk);
        rd_chk(tag, exp);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        do_reset();

        // R2 R3 R4 R5: table of bus cycles with expected read bytes
        for (int i = 0; i < NV; i++) begin
            case (VEC[i][19:16])
                4'h4:    rd_chk($sformatf("table %0d (R2 R4 R5)", i), VEC[i][7:0]);
                4'h5:    repeat (int'(VEC[i][15:8])) @(posedge clk);
                default: op(VEC[i][19:16], VEC[i][15:8]);
            endcase
        end
        check("R5 order code", {viol_flag, 5'b0, viol_code}, 8'h81);

        // R10: six more repeats of page 1 pass, the seventh hits the limit; code stays order
        for (int i = 0; i < 7; i++)
            prog_status("R6 repeat page 1", 8'h01, (i < 6) ? 8'h40 : 8'h41);
        check("R10 sticky first code", {viol_flag, 5'b0, viol_code}, 8'h81);

        // R1: reset state
        do_reset();
        @(negedge clk);
        check("R1 ready", {7'b0, ready}, 8'h01);
        check("R1 viol flag and code", {viol_flag, 5'b0, viol_code}, 8'h00);
        check("R1 dout buffer", io_dout, 8'hFF);
        op(4'h1, 8'h70);
        rd_chk("R1 status after reset", 8'h40);

        // R6: block 1 page 0, eight programs pass, ninth fails with limit code
        for (int i = 0; i < 9; i++)
            prog_status("R6 partial programs", 8'h40, (i < 8) ? 8'h40 : 8'h41);
        check("R6 limit code", {viol_flag, 5'b0, viol_code}, 8'h82);

        // R9 and R3: erase block 1, measure busy length, restart page order
        op(4'h1, 8'h60);
        op(4'h2, 8'h40); op(4'h2, 8'h00); op(4'h2, 8'h00);
        op(4'h1, 8'hD0);
        begin
            int lows = 0;
            @(negedge clk);
            while (!ready && lows < 1000) begin
                lows++;
                @(negedge clk);
            end
            check("R3 busy cycles after erase", 8'(lows), 8'd16);
        end
        op(4'h1, 8'h70);
        rd_chk("R9 erase clears fail", 8'h40);
        prog(8'h40, 8'h77);
        begin
            int lows = 0;
            @(negedge clk);
            while (!ready && lows < 1000) begin
                lows++;
                @(negedge clk);
            end
            check("R3 busy cycles after program", 8'(lows), 8'd16);
        end
        op(4'h1, 8'h70);
        rd_chk("R9 page 0 after erase", 8'h40);

        // R11: block 2 full sweep, then last-page repeat and a stray page 0
        for (int p = 0; p < 64; p++) begin
            prog(8'h80 | 8'(p), 8'h00);
            repeat (17) @(posedge clk);
        end
        op(4'h1, 8'h70);
        rd_chk("R11 page 63 passes", 8'h40);
        prog_status("R11 page 63 repeat", 8'hBF, 8'h40);
        prog_status("R11 page 0 after last", 8'h80, 8'h41);

        // R7: command while busy is ignored and recorded
        do_reset();
        prog(8'h00, 8'h12);
        op(4'h1, 8'h70);
        op(4'h1, 8'h80);
        rd_chk("R7 still status while busy", 8'h00);
        check("R7 busy code", {viol_flag, 5'b0, viol_code}, 8'h83);
        repeat (20) @(posedge clk);
        rd_chk("R7 status after busy", 8'h40);

        // R8: reset command ends busy and leaves status mode
        prog(8'h01, 8'h34);
        op(4'h1, 8'h70);
        rd_chk("R8 busy before abort", 8'h00);
        op(4'h1, 8'hFF);
        @(negedge clk);
        check("R8 ready after abort", {7'b0, ready}, 8'h01);
        rd_chk("R8 buffer byte after abort", 8'hFF);

        finish_run();
    end
endmodule